// File: doc/BRIEF.md
# Interrupt Wake and Sleep Controller

This block sits between an interrupt distributor and the power controller of a small cluster of cores. Each incoming interrupt carries a target mask. A mask with one bit set names a single-target interrupt. A mask with more than one bit set names a multi-target interrupt, which may go to any core in the mask. An empty mask is an error. Software gives each core a sleep flag. A core whose flag is set is never sent an interrupt. Instead, a single-target interrupt for that core is held, and a wake request is raised toward the power controller. The held interrupt is delivered once software clears the flag.

Multi-target interrupts go only to cores that are awake. Among the awake cores, a core whose `cpu_active` input is high is preferred. When several cores are equally eligible, a round-robin pointer breaks the tie. A controller-wide Sleep bit starts a quiescence handshake. The `quiescent` output rises only when all of these hold for a run of consecutive cycles: every core flag is set, nothing is held, nothing is being delivered and no interrupt is arriving.

Top module: `irq_wake_ctrl`

## Requirements
- R1: A single-target interrupt aimed at a core whose sleep flag is 1 produces no delivery. From the next cycle, it raises `wake_req` for that core.
- R2: A single-target interrupt aimed at an awake core is delivered to that core on the next cycle, with its id, whatever that core's `cpu_active` is.
- R3: A multi-target interrupt picks among the target cores that are awake and not releasing a held interrupt. It uses only the active ones among them when any of them is active. Within the chosen set, it takes the first core found scanning upward (with wrap) from a round-robin pointer, and the pointer then moves to the core after the winner. The pointer resets to core 0.
- R4: `wake_req` of a core stays high until a flag write clears that core's sleep flag. It drops in the cycle after that write edge.
- R5: No delivery is started to a core while its sleep flag is 1.
- R6: The held interrupt is delivered on the edge after the flag is cleared. A further single-target interrupt for a core that already holds one is discarded, and the first id is kept. One that arrives while the core is releasing is held and delivered on the following edge.
- R7: An interrupt with an empty target mask, or a multi-target interrupt with no awake target, is dropped. It raises `irq_err` for exactly one cycle.
- R8: `quiescent` rises after four consecutive edges at which Sleep is 1, all sleep flags are 1, nothing is held, no delivery pulse is high, no interrupt arrives and no flag write occurs.
- R9: While any sleep flag is 0, `quiescent` stays 0.
- R10: Writing Sleep to 0, or breaking any condition of R8, clears `quiescent` at that same edge.
- R11: Reset is synchronous and active-low. It clears all flags, Sleep, `quiescent`, `wake_req`, `dlv_valid` and `irq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | Interrupt present this cycle |
| irq_tgt | input | N | Target core mask |
| irq_id | input | IDW | Interrupt id |
| cpu_active | input | N | Per-core activity hint |
| pd_we | input | 1 | Write strobe for the sleep flags |
| pd_wdata | input | N | New sleep flag vector |
| ctl_we | input | 1 | Write strobe for Sleep |
| ctl_d | input | 1 | New Sleep value |
| dlv_valid | output | N | One-cycle delivery pulse per core |
| dlv_id | output | N*IDW | Delivered id per core, core c at bits c*IDW upward |
| wake_req | output | N | Wake request per core |
| quiescent | output | 1 | Controller quiescent status |
| irq_err | output | 1 | Dropped-interrupt pulse |

## Verification
The assertions assume that reset is low from time zero through at least one edge. They also assume every input is a known value at each rising edge, and that the flag write port is the only way a flag changes. The bench drives all inputs at falling edges and never leaves one undriven. It holds reset for three edges at the start. It then mixes directed sequences (sleeping cores, release collisions, the quiescence run) with a long random run where flag and Sleep writes are sparse, so both held and quiescent states are reached.

// File: rtl/irq_wake_ctrl.sv
`timescale 1ns/1ps
module irq_wake_ctrl #(
  parameter int N    = 4,
  parameter int IDW  = 8,
  parameter int QDLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_valid,
  input  logic [N-1:0]     irq_tgt,
  input  logic [IDW-1:0]   irq_id,
  input  logic [N-1:0]     cpu_active,
  input  logic             pd_we,
  input  logic [N-1:0]     pd_wdata,
  input  logic             ctl_we,
  input  logic             ctl_d,
  output logic [N-1:0]     dlv_valid,
  output logic [N*IDW-1:0] dlv_id,
  output logic [N-1:0]     wake_req,
  output logic             quiescent,
  output logic             irq_err
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);
  localparam int QW = $clog2(QDLY + 1);

  logic [N-1:0]   pd_q, held_q, dlv_q;
  logic [IDW-1:0] hid_q [N];
  logic [IDW-1:0] did_q [N];
  logic           ctl_q, q_q, err_q;
  logic [QW-1:0]  qcnt_q;
  logic [PW-1:0]  rr_q;

  logic [N-1:0]   rel, cand, act, pool;
  logic [CW-1:0]  tcnt;
  logic           single, multi, mgrant, err_n, qcond;
  logic [PW-1:0]  pick;
  logic [N-1:0]   held_n, dlv_n;
  logic [IDW-1:0] hid_n [N];
  logic [IDW-1:0] did_n [N];

  assign rel    = held_q & ~pd_q;
  assign tcnt   = CW'($countones(irq_tgt));
  assign single = irq_valid && (tcnt == CW'(1));
  assign multi  = irq_valid && (tcnt > CW'(1));
  assign cand   = irq_tgt & ~pd_q & ~rel;
  assign act    = cand & cpu_active;
  assign pool   = (|act) ? act : cand;
  assign mgrant = multi && (|cand);
  assign err_n  = irq_valid && ((tcnt == '0) || (multi && !(|cand)));
  assign qcond  = ctl_q && (&pd_q) && (held_q == '0) && (dlv_q == '0)
                  && !irq_valid && !pd_we;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % N;
      if (!found && pool[idx]) begin
        pick  = PW'(idx);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) begin
      held_n[c] = held_q[c] & ~rel[c];
      hid_n[c]  = hid_q[c];
      dlv_n[c]  = rel[c];
      did_n[c]  = rel[c] ? hid_q[c] : did_q[c];
      if (single && irq_tgt[c]) begin
        if (pd_q[c]) begin
          if (!held_q[c]) begin
            held_n[c] = 1'b1;
            hid_n[c]  = irq_id;
          end
        end else if (rel[c]) begin
          held_n[c] = 1'b1;
          hid_n[c]  = irq_id;
        end else begin
          dlv_n[c] = 1'b1;
          did_n[c] = irq_id;
        end
      end
      if (mgrant && (pick == PW'(c))) begin
        dlv_n[c] = 1'b1;
        did_n[c] = irq_id;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_q   <= '0;
      held_q <= '0;
      dlv_q  <= '0;
      ctl_q  <= 1'b0;
      q_q    <= 1'b0;
      err_q  <= 1'b0;
      qcnt_q <= '0;
      rr_q   <= '0;
      for (int c = 0; c < N; c++) begin
        hid_q[c] <= '0;
        did_q[c] <= '0;
      end
    end else begin
      held_q <= held_n;
      dlv_q  <= dlv_n;
      err_q  <= err_n;
      for (int c = 0; c < N; c++) begin
        hid_q[c] <= hid_n[c];
        did_q[c] <= did_n[c];
      end
      if (pd_we)  pd_q  <= pd_wdata;
      if (ctl_we) ctl_q <= ctl_d;
      if ((ctl_we && !ctl_d) || !qcond) begin
        q_q    <= 1'b0;
        qcnt_q <= '0;
      end else if (qcnt_q == QW'(QDLY - 1)) begin
        q_q <= 1'b1;
      end else begin
        qcnt_q <= qcnt_q + QW'(1);
      end
      if (mgrant) rr_q <= (pick == PW'(N - 1)) ? '0 : pick + PW'(1);
    end
  end

  assign dlv_valid = dlv_q;
  assign wake_req  = held_q & pd_q;
  assign quiescent = q_q;
  assign irq_err   = err_q;

  for (genvar g = 0; g < N; g++) begin : g_id
    assign dlv_id[g*IDW +: IDW] = did_q[g];
  end

  AST_NO_DLV_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dlv_valid & $past(pd_q)) == '0)); // R5
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_we |=> ((wake_req & $past(wake_req)) == $past(wake_req))); // R4
  AST_Q_ALL_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> (ctl_q && (&pd_q))); // R9
  AST_Q_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    quiescent |-> (held_q == '0)); // R8
  AST_Q_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_d) |=> !quiescent); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> $past(irq_valid)); // R7
  AST_WAKE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (single && ((irq_tgt & pd_q) != '0) && !pd_we) |=> ((wake_req & $past(irq_tgt)) != '0)); // R1

endmodule

// File: tb/sim_irq_wake_ctrl.sv
`timescale 1ns/1ps
module sim_irq_wake_ctrl;
  localparam int N = 4, IDW = 8, QDLY = 4;

  logic clk = 1'b0;
  logic rst_n, irq_valid, pd_we, ctl_we, ctl_d;
  logic [N-1:0] irq_tgt, cpu_active, pd_wdata;
  logic [IDW-1:0] irq_id;
  logic [N-1:0] dlv_valid, wake_req;
  logic [N*IDW-1:0] dlv_id;
  logic quiescent, irq_err;

  always #5 clk = ~clk;

  irq_wake_ctrl #(.N(N), .IDW(IDW), .QDLY(QDLY)) u0 (
    .clk, .rst_n, .irq_valid, .irq_tgt, .irq_id, .cpu_active, .pd_we,
    .pd_wdata, .ctl_we, .ctl_d, .dlv_valid, .dlv_id, .wake_req,
    .quiescent, .irq_err);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [N-1:0] m_pd, m_held, m_dv;
  int m_hid [N];
  int m_did [N];
  bit m_ctl, m_q, m_err;
  int m_qc, m_rr;

  task automatic chk(input int a, input int e, input string tag, input string what);
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, a, e);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] rel, nheld, ndv, cand, act, pool;
    int nhid [N];
    int ndid [N];
    int cnt, tc, pk;
    bit nerr, cond;
    if (!rst_n) begin
      m_pd = '0; m_held = '0; m_dv = '0; m_ctl = 0; m_q = 0; m_err = 0;
      m_qc = 0; m_rr = 0;
      for (int c = 0; c < N; c++) begin m_hid[c] = 0; m_did[c] = 0; end
      return;
    end
    rel = m_held & ~m_pd;
    nheld = m_held & ~rel;
    ndv = rel;
    for (int c = 0; c < N; c++) begin
      nhid[c] = m_hid[c];
      ndid[c] = rel[c] ? m_hid[c] : m_did[c];
    end
    nerr = 0;
    cnt = 0; tc = 0;
    for (int c = 0; c < N; c++) if (irq_tgt[c]) begin cnt++; tc = c; end
    if (irq_valid) begin
      if (cnt == 0) nerr = 1;
      else if (cnt == 1) begin
        if (m_pd[tc]) begin
          if (!m_held[tc]) begin nheld[tc] = 1; nhid[tc] = int'(irq_id); end
        end else if (rel[tc]) begin
          nheld[tc] = 1; nhid[tc] = int'(irq_id);
        end else begin
          ndv[tc] = 1; ndid[tc] = int'(irq_id);
        end
      end else begin
        cand = irq_tgt & ~m_pd & ~rel;
        if (cand == '0) nerr = 1;
        else begin
          act = cand & cpu_active;
          pool = (act != '0) ? act : cand;
          pk = -1;
          for (int k = 0; k < N; k++)
            if (pk < 0 && pool[(m_rr + k) % N]) pk = (m_rr + k) % N;
          ndv[pk] = 1; ndid[pk] = int'(irq_id);
          m_rr = (pk + 1) % N;
        end
      end
    end
    cond = m_ctl && (&m_pd) && (m_held == '0) && (m_dv == '0) && !irq_valid && !pd_we;
    if ((ctl_we && !ctl_d) || !cond) begin m_q = 0; m_qc = 0; end
    else if (m_qc == QDLY - 1) m_q = 1;
    else m_qc++;
    if (pd_we) m_pd = pd_wdata;
    if (ctl_we) m_ctl = ctl_d;
    m_held = nheld; m_dv = ndv; m_err = nerr;
    for (int c = 0; c < N; c++) begin m_hid[c] = nhid[c]; m_did[c] = ndid[c]; end
  endtask

  task automatic compare();
    chk(int'(dlv_valid), int'(m_dv), "R2/R3/R5", "dlv_valid");
    for (int c = 0; c < N; c++)
      if (m_dv[c]) chk(int'(dlv_id[c*IDW +: IDW]), m_did[c], "R2/R6", "dlv_id");
    chk(int'(wake_req), int'(m_held & m_pd), "R1/R4", "wake_req");
    chk(int'(quiescent), int'(m_q), "R8/R9/R10", "quiescent");
    chk(int'(irq_err), int'(m_err), "R7", "irq_err");
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    irq_valid = 0; pd_we = 0; ctl_we = 0;
  endtask

  task automatic irq(input logic [N-1:0] t, input int id);
    irq_valid = 1; irq_tgt = t; irq_id = IDW'(id);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_valid = 0; irq_tgt = '0; irq_id = '0; cpu_active = '0;
    pd_we = 0; pd_wdata = '0; ctl_we = 0; ctl_d = 0;
    @(negedge clk);
    repeat (3) step();
    chk(int'(dlv_valid), 0, "R11", "reset dlv");
    chk(int'(wake_req), 0, "R11", "reset wake");
    chk(int'(quiescent), 0, "R11", "reset quiescent");
    rst_n = 1;
    step();

    // R2: inactive single target still delivered
    cpu_active = '0; irq(4'b0010, 5); step();
    chk(int'(dlv_valid), 2, "R2", "single deliver");
    chk(int'(dlv_id[1*IDW +: IDW]), 5, "R2", "single id");

    // R3: active preferred, then round robin
    cpu_active = 4'b0100; irq(4'b0111, 6); step();
    chk(int'(dlv_valid), 4, "R3", "active preferred");
    cpu_active = '0; irq(4'b1011, 7); step();
    chk(int'(dlv_valid), 8, "R3", "rr from 3");
    irq(4'b1011, 8); step();
    chk(int'(dlv_valid), 1, "R3", "rr wrap to 0");

    // R1 R5 R6 R4: sleeping core 0
    pd_we = 1; pd_wdata = 4'b0001; step();
    irq(4'b0001, 9); step();
    chk(int'(wake_req), 1, "R1", "wake raised");
    chk(int'(dlv_valid), 0, "R5", "no delivery asleep");
    irq(4'b0001, 10); step();
    cpu_active = 4'b0001; irq(4'b0011, 11); step();
    chk(int'(dlv_valid), 2, "R5", "multi skips sleeper");
    cpu_active = '0;
    repeat (3) step();
    chk(int'(wake_req), 1, "R4", "wake held");
    pd_we = 1; pd_wdata = 4'b0000; step();
    chk(int'(wake_req), 0, "R4", "wake dropped");
    irq(4'b0001, 12); step();
    chk(int'(dlv_valid), 1, "R6", "held released");
    chk(int'(dlv_id[0 +: IDW]), 9, "R6", "first id kept");
    step();
    chk(int'(dlv_valid), 1, "R6", "collided one next");
    chk(int'(dlv_id[0 +: IDW]), 12, "R6", "collided id");

    // R7
    irq(4'b0000, 1); step();
    chk(int'(irq_err), 1, "R7", "empty mask err");
    step();
    chk(int'(irq_err), 0, "R7", "err one cycle");
    pd_we = 1; pd_wdata = 4'b0011; step();
    irq(4'b0011, 2); step();
    chk(int'(irq_err), 1, "R7", "multi all asleep");

    // R8 R10
    pd_we = 1; pd_wdata = 4'b1111; ctl_we = 1; ctl_d = 1; step();
    repeat (3) step();
    chk(int'(quiescent), 0, "R8", "not yet");
    step();
    chk(int'(quiescent), 1, "R8", "quiescent up");
    ctl_we = 1; ctl_d = 0; step();
    chk(int'(quiescent), 0, "R10", "sleep cleared");

    // R9
    pd_we = 1; pd_wdata = 4'b0111; ctl_we = 1; ctl_d = 1; step();
    repeat (8) step();
    chk(int'(quiescent), 0, "R9", "flag low blocks");
    ctl_we = 1; ctl_d = 0; pd_we = 1; pd_wdata = '0; step();

    for (int i = 0; i < 6000; i++) begin
      irq_valid = ($urandom % 2) == 0;
      irq_tgt = N'($urandom);
      irq_id = IDW'($urandom);
      cpu_active = N'($urandom);
      if ($urandom % 20 == 0) begin pd_we = 1; pd_wdata = ($urandom % 3 == 0) ? '1 : N'($urandom); end
      if ($urandom % 30 == 0) begin ctl_we = 1; ctl_d = ($urandom % 3) != 0; end
      if ($urandom % 4 == 0) irq_valid = 0;
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule